// File: doc/BRIEF.md
# Dock Loop Counter and Predicate Unit

This block keeps the loop state and the condition flags of one dock in a fabric-connected processor. It holds an outer repeat counter that covers a whole group of instructions and an inner repeat counter that covers a single move instruction. The inner counter also has a distinct "repeat forever" state. The block also holds two general-purpose flags, A and B, and a control flag C. From this state it evaluates a 3-bit predicate code for the instruction that sits on deck.

The on-deck stage drives the block through strobes:
- a set instruction executing, with its source and destination fields;
- one iteration of a move, with its data-in and token-in bits;
- a move leaving the deck;
- a torpedo being consumed.

It also supplies the instruction payload, the low bits of the data latch, the signal bit of the incoming packet and a flag from the attached ship. In return it reports:
- whether the predicate holds;
- whether either counter is exhausted;
- whether the inner counter is in its forever state;
- a one-cycle pulse whenever the outer counter is written to zero, which the hatch logic uses to unseal;
- the torpedo acknowledge path latch.

A parameter selects whether the unit serves an input dock or an output dock. The two differ only in where C is loaded from.

Top module: `dockLoopUnit`

## Requirements
- R1: predTrue follows predCode against the state seen at the ports. Code 111 is always true. Code 110 is true when the outer counter is nonzero. Codes 000/001 need A=0/A=1, codes 010/011 need B=0/B=1, and codes 100/101 need C=0/C=1, each of these also only while the outer counter is nonzero.
- R2: A set with destination 000 writes the outer counter from payload[OLC_W-1:0] (source 00), from dataLatch[OLC_W-1:0] (source 01), or from the counter minus one (source 10). Decrementing at zero leaves it at zero. The new value is visible on olcZero one cycle after the strobe.
- R3: abortTorp forces the outer counter to zero on the next edge, and it overrides a set to the outer counter in the same cycle.
- R4: olcZeroEvt is high for exactly the one cycle after any write that leaves the outer counter at zero (a set, a decrement or an abort), and low otherwise.
- R5: A set with destination 001 writes the inner counter from payload[ILC_W-1:0] (source 00), from dataLatch[ILC_W-1:0] (source 01), or puts it in the forever state (source 10, shown on ilcInf).
- R6: Each moveStep decrements a finite nonzero inner counter. A zero counter stays zero, shown on ilcZero. The forever state is left unchanged.
- R7: moveEnd sets the inner counter to one, finite (ilcZero=0, ilcInf=0), even from zero or from the forever state.
- R8: A set with destination 111 loads A from payload[5:0] and B from payload[11:6]. In each field, bit5 selects A, bit4 selects not-A, bit3 selects B, bit2 selects not-B, bit1 selects C and bit0 selects not-C. The new flag is the OR of the selected old values, so an all-zero field gives 0.
- R9: In an input dock (OUTPUT_DOCK=0), a moveStep with moveDi or moveTi set loads C from sigBit. With both bits clear, C is unchanged.
- R10: In an output dock (OUTPUT_DOCK=1), a moveStep with moveDi set loads C from shipFlag. With moveDi clear and moveTi set, it loads C from sigBit.
- R11: A set with destination 010 loads ackPath from payload[ACK_W-1:0].
- R12: After reset the outer counter is 0, the inner counter is 1 and finite, A, B and C are 0, ackPath is 0 and olcZeroEvt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predCode | input | 3 | Predicate code of the on-deck instruction |
| execSet | input | 1 | A set instruction executes this cycle |
| setSrc | input | 2 | Source field of the set instruction |
| setDst | input | 3 | Destination field of the set instruction |
| payload | input | 12 | Payload field of the set instruction |
| dataLatch | input | DATA_W (37) | Current data latch value |
| moveStep | input | 1 | One iteration of a move executes |
| moveEnd | input | 1 | The move instruction leaves the deck |
| moveDi | input | 1 | Move takes a data input |
| moveTi | input | 1 | Move takes a token input |
| sigBit | input | 1 | Signal bit of the incoming packet |
| shipFlag | input | 1 | Flag value offered by the ship |
| abortTorp | input | 1 | A torpedo is consumed this cycle |
| predTrue | output | 1 | Predicate of predCode holds |
| olcZero | output | 1 | Outer counter is zero |
| ilcZero | output | 1 | Inner counter is zero and finite |
| ilcInf | output | 1 | Inner counter is in the forever state |
| olcZeroEvt | output | 1 | Pulse after a write that leaves the outer counter at zero |
| ackPath | output | ACK_W (11) | Torpedo acknowledge path latch |

## Verification
The hardest situation to reach is an abort that coincides with a set to the outer counter. A consumed torpedo and a set instruction cannot both come from ordinary sequencing, so the bench drives both strobes in one cycle with a nonzero payload and expects the counter to be zero and the pulse to fire. The C flag and the two user flags are never visible directly. The bench therefore reads them back by holding the outer counter nonzero and probing each relevant predicate code after every change. It runs an output-dock instance beside the input-dock one, so that the same move strobes show both sources of C.

// File: rtl/dockLoopPkg.sv
package dockLoopPkg;
  localparam int PAY_W = 12;
  localparam int FLAG_FIELD_W = 6;

  localparam logic [2:0] DST_OLC   = 3'b000;
  localparam logic [2:0] DST_ILC   = 3'b001;
  localparam logic [2:0] DST_ACK   = 3'b010;
  localparam logic [2:0] DST_FLAGS = 3'b111;

  localparam logic [1:0] SRC_PAY  = 2'b00;
  localparam logic [1:0] SRC_DATA = 2'b01;
  localparam logic [1:0] SRC_ALT  = 2'b10;

  typedef struct packed {
    logic olcClear;
    logic olcLoadPay;
    logic olcLoadData;
    logic olcDec;
    logic ilcLoadPay;
    logic ilcLoadData;
    logic ilcLoadInf;
    logic ilcToOne;
    logic ilcDec;
    logic ackLoad;
    logic flagLoad;
    logic cLoad;
    logic cFromShip;
  } dockStrobes_t;
endpackage

// File: rtl/dockLoopCtrl.sv
module dockLoopCtrl
  import dockLoopPkg::*;
#(
  parameter bit OUTPUT_DOCK = 1'b0
) (
  input  logic         execSet,
  input  logic [1:0]   setSrc,
  input  logic [2:0]   setDst,
  input  logic         moveStep,
  input  logic         moveEnd,
  input  logic         moveDi,
  input  logic         moveTi,
  input  logic         abortTorp,
  output dockStrobes_t st
);
  logic setOlc, setIlc;
  logic cTake, cShip;

  assign setOlc = execSet && (setDst == DST_OLC);
  assign setIlc = execSet && (setDst == DST_ILC);

  generate
    if (OUTPUT_DOCK) begin : g_outDock
      // ship value has priority when data is taken
      assign cTake = moveStep && (moveDi || moveTi);
      assign cShip = moveDi;
    end else begin : g_inDock
      assign cTake = moveStep && (moveDi || moveTi);
      assign cShip = 1'b0;
    end
  endgenerate

  always_comb begin
    st             = '0;
    // torpedo beats any same-cycle set of the outer counter (R3)
    st.olcClear    = abortTorp;
    st.olcLoadPay  = !abortTorp && setOlc && (setSrc == SRC_PAY);
    st.olcLoadData = !abortTorp && setOlc && (setSrc == SRC_DATA);
    st.olcDec      = !abortTorp && setOlc && (setSrc == SRC_ALT);
    st.ilcLoadPay  = setIlc && (setSrc == SRC_PAY);
    st.ilcLoadData = setIlc && (setSrc == SRC_DATA);
    st.ilcLoadInf  = setIlc && (setSrc == SRC_ALT);
    st.ilcToOne    = !setIlc && moveEnd;
    st.ilcDec      = !setIlc && !moveEnd && moveStep;
    st.ackLoad     = execSet && (setDst == DST_ACK);
    st.flagLoad    = execSet && (setDst == DST_FLAGS);
    st.cLoad       = cTake;
    st.cFromShip   = cShip;
  end
endmodule

// File: rtl/dockLoopData.sv
module dockLoopData
  import dockLoopPkg::*;
#(
  parameter int OLC_W   = 6,
  parameter int ILC_W   = 6,
  parameter int ACK_W   = 11,
  parameter int DLO_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dockStrobes_t       st,
  input  logic [PAY_W-1:0]   payload,
  input  logic [DLO_W-1:0]   dataLo,
  input  logic               sigBit,
  input  logic               shipFlag,
  input  logic [2:0]         predCode,
  output logic               predTrue,
  output logic               olcZero,
  output logic               ilcZero,
  output logic               ilcInf,
  output logic               olcZeroEvt,
  output logic [ACK_W-1:0]   ackPath
);
  localparam logic [ILC_W-1:0] ILC_ONE = ILC_W'(1);

  logic [OLC_W-1:0] olcQ, olcNext;
  logic             olcWrite;
  logic [ILC_W-1:0] ilcQ;
  logic             infQ;
  logic             flagA, flagB, flagC;
  logic             newA, newB;
  logic             evtQ;
  logic [ACK_W-1:0] ackQ;

  function automatic logic orTerms(input logic [FLAG_FIELD_W-1:0] f,
                                   input logic a, input logic b, input logic c);
    return (f[5] & a) | (f[4] & ~a) | (f[3] & b) |
           (f[2] & ~b) | (f[1] & c) | (f[0] & ~c);
  endfunction

  assign newA = orTerms(payload[FLAG_FIELD_W-1:0], flagA, flagB, flagC);
  assign newB = orTerms(payload[2*FLAG_FIELD_W-1:FLAG_FIELD_W], flagA, flagB, flagC);

  always_comb begin
    olcWrite = 1'b1;
    olcNext  = olcQ;
    if (st.olcClear)         olcNext = '0;
    else if (st.olcLoadPay)  olcNext = payload[OLC_W-1:0];
    else if (st.olcLoadData) olcNext = dataLo[OLC_W-1:0];
    else if (st.olcDec)      olcNext = (olcQ == '0) ? '0 : olcQ - 1'b1;
    else                     olcWrite = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      olcQ  <= '0;
      evtQ  <= 1'b0;
      ilcQ  <= ILC_ONE;
      infQ  <= 1'b0;
      flagA <= 1'b0;
      flagB <= 1'b0;
      flagC <= 1'b0;
      ackQ  <= '0;
    end else begin
      olcQ <= olcNext;
      evtQ <= olcWrite && (olcNext == '0);

      if (st.ilcLoadPay) begin
        ilcQ <= payload[ILC_W-1:0];
        infQ <= 1'b0;
      end else if (st.ilcLoadData) begin
        ilcQ <= dataLo[ILC_W-1:0];
        infQ <= 1'b0;
      end else if (st.ilcLoadInf) begin
        infQ <= 1'b1;
      end else if (st.ilcToOne) begin
        ilcQ <= ILC_ONE;
        infQ <= 1'b0;
      end else if (st.ilcDec && !infQ && ilcQ != '0) begin
        ilcQ <= ilcQ - 1'b1;
      end

      if (st.flagLoad) begin
        flagA <= newA;
        flagB <= newB;
      end
      if (st.cLoad) flagC <= st.cFromShip ? shipFlag : sigBit;
      if (st.ackLoad) ackQ <= payload[ACK_W-1:0];
    end
  end

  always_comb begin
    unique case (predCode)
      3'b000:  predTrue = (olcQ != '0) && !flagA;
      3'b001:  predTrue = (olcQ != '0) &&  flagA;
      3'b010:  predTrue = (olcQ != '0) && !flagB;
      3'b011:  predTrue = (olcQ != '0) &&  flagB;
      3'b100:  predTrue = (olcQ != '0) && !flagC;
      3'b101:  predTrue = (olcQ != '0) &&  flagC;
      3'b110:  predTrue = (olcQ != '0);
      default: predTrue = 1'b1;
    endcase
  end

  assign olcZero    = (olcQ == '0);
  assign ilcZero    = !infQ && (ilcQ == '0);
  assign ilcInf     = infQ;
  assign olcZeroEvt = evtQ;
  assign ackPath    = ackQ;
endmodule

// File: rtl/dockLoopUnit.sv
module dockLoopUnit
  import dockLoopPkg::*;
#(
  parameter int OLC_W       = 6,
  parameter int ILC_W       = 6,
  parameter int ACK_W       = 11,
  parameter int DATA_W      = 37,
  parameter bit OUTPUT_DOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        predCode,
  input  logic              execSet,
  input  logic [1:0]        setSrc,
  input  logic [2:0]        setDst,
  input  logic [PAY_W-1:0]  payload,
  input  logic [DATA_W-1:0] dataLatch,
  input  logic              moveStep,
  input  logic              moveEnd,
  input  logic              moveDi,
  input  logic              moveTi,
  input  logic              sigBit,
  input  logic              shipFlag,
  input  logic              abortTorp,
  output logic              predTrue,
  output logic              olcZero,
  output logic              ilcZero,
  output logic              ilcInf,
  output logic              olcZeroEvt,
  output logic [ACK_W-1:0]  ackPath
);
  localparam int DLO_W = (OLC_W > ILC_W) ? OLC_W : ILC_W;

  dockStrobes_t st;
  logic         unusedDataHi;

  assign unusedDataHi = ^dataLatch[DATA_W-1:DLO_W];

  dockLoopCtrl #(.OUTPUT_DOCK(OUTPUT_DOCK)) u_ctrl (
    .execSet(execSet), .setSrc(setSrc), .setDst(setDst),
    .moveStep(moveStep), .moveEnd(moveEnd), .moveDi(moveDi),
    .moveTi(moveTi), .abortTorp(abortTorp), .st(st)
  );

  dockLoopData #(.OLC_W(OLC_W), .ILC_W(ILC_W), .ACK_W(ACK_W), .DLO_W(DLO_W)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .payload(payload),
    .dataLo(dataLatch[DLO_W-1:0]), .sigBit(sigBit), .shipFlag(shipFlag),
    .predCode(predCode), .predTrue(predTrue), .olcZero(olcZero),
    .ilcZero(ilcZero), .ilcInf(ilcInf), .olcZeroEvt(olcZeroEvt),
    .ackPath(ackPath)
  );
endmodule

// File: rtl/dockLoopChecker.sv
module dockLoopChecker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] predCode,
  input logic       predTrue,
  input logic       olcZero,
  input logic       ilcZero,
  input logic       ilcInf,
  input logic       olcZeroEvt,
  input logic       execSet,
  input logic       moveEnd,
  input logic       abortTorp
);
  p_always_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    (predCode == 3'b111) |-> predTrue);

  p_gated_by_olc_r1: assert property (@(posedge clk) disable iff (!rstN)
    (olcZero && predCode != 3'b111) |-> !predTrue);

  p_abort_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    abortTorp |=> (olcZero && olcZeroEvt));

  p_evt_means_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    olcZeroEvt |-> olcZero);

  p_inf_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ilcInf && !execSet && !moveEnd) |=> ilcInf);

  p_end_gives_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (moveEnd && !execSet) |=> (!ilcZero && !ilcInf));
endmodule

bind dockLoopUnit dockLoopChecker chk (
  .clk(clk), .rstN(rstN), .predCode(predCode), .predTrue(predTrue),
  .olcZero(olcZero), .ilcZero(ilcZero), .ilcInf(ilcInf),
  .olcZeroEvt(olcZeroEvt), .execSet(execSet), .moveEnd(moveEnd),
  .abortTorp(abortTorp)
);

// File: tb/tb_dockLoopUnit.sv
module tb_dockLoopUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  predCode = 3'b111;
  logic        execSet = 0, moveStep = 0, moveEnd = 0, moveDi = 0, moveTi = 0;
  logic        sigBit = 0, shipFlag = 0, abortTorp = 0;
  logic [1:0]  setSrc = 0;
  logic [2:0]  setDst = 0;
  logic [11:0] payload = 0;
  logic [36:0] dataLatch = 0;
  logic        predTrue, olcZero, ilcZero, ilcInf, olcZeroEvt;
  logic [10:0] ackPath;
  logic        predTrueO, olcZeroO, ilcZeroO, ilcInfO, olcZeroEvtO;
  logic [10:0] ackPathO;

  always #4 clk = ~clk;

  dockLoopUnit dut (
    .clk(clk), .rstN(rstN), .predCode(predCode), .execSet(execSet),
    .setSrc(setSrc), .setDst(setDst), .payload(payload), .dataLatch(dataLatch),
    .moveStep(moveStep), .moveEnd(moveEnd), .moveDi(moveDi), .moveTi(moveTi),
    .sigBit(sigBit), .shipFlag(shipFlag), .abortTorp(abortTorp),
    .predTrue(predTrue), .olcZero(olcZero), .ilcZero(ilcZero), .ilcInf(ilcInf),
    .olcZeroEvt(olcZeroEvt), .ackPath(ackPath)
  );

  dockLoopUnit #(.OUTPUT_DOCK(1'b1)) dutO (
    .clk(clk), .rstN(rstN), .predCode(predCode), .execSet(execSet),
    .setSrc(setSrc), .setDst(setDst), .payload(payload), .dataLatch(dataLatch),
    .moveStep(moveStep), .moveEnd(moveEnd), .moveDi(moveDi), .moveTi(moveTi),
    .sigBit(sigBit), .shipFlag(shipFlag), .abortTorp(abortTorp),
    .predTrue(predTrueO), .olcZero(olcZeroO), .ilcZero(ilcZeroO), .ilcInf(ilcInfO),
    .olcZeroEvt(olcZeroEvtO), .ackPath(ackPathO)
  );

  localparam int K_OLCZ = 0, K_ILCZ = 1, K_INF = 2, K_EVT = 3, K_ACK = 4,
                 K_PRED = 5, K_PREDO = 6;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // reference state
  int mOlc = 0, mIlc = 1, mAck = 0;
  bit mInf = 0, mA = 0, mB = 0, mC = 0, mAo = 0, mBo = 0, mCo = 0, mEvt = 0;

  function automatic bit pickOr(input logic [5:0] f, input bit a, input bit b, input bit c);
    return (f[5] && a) || (f[4] && !a) || (f[3] && b) || (f[2] && !b) ||
           (f[1] && c) || (f[0] && !c);
  endfunction

  function automatic bit predModel(input logic [2:0] code, input bit a, input bit b,
                                   input bit c, input int olc);
    bit live = (olc != 0);
    case (code)
      3'b000: return live && !a;
      3'b001: return live && a;
      3'b010: return live && !b;
      3'b011: return live && b;
      3'b100: return live && !c;
      3'b101: return live && c;
      3'b110: return live;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int sampleKind(input int kind);
    case (kind)
      K_OLCZ:  return int'(olcZero);
      K_ILCZ:  return int'(ilcZero);
      K_INF:   return int'(ilcInf);
      K_EVT:   return int'(olcZeroEvt);
      K_ACK:   return int'(ackPath);
      K_PRED:  return int'(predTrue);
      default: return int'(predTrueO);
    endcase
  endfunction

  task automatic expectItem(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares pending expectations at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = sampleKind(it.kind);
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s: kind %0d actual %0d expected %0d", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic pushState(input string tag);
    expectItem(K_OLCZ, int'(mOlc == 0), tag);
    expectItem(K_ILCZ, int'(!mInf && mIlc == 0), tag);
    expectItem(K_INF, int'(mInf), tag);
    expectItem(K_EVT, int'(mEvt), tag);
    expectItem(K_ACK, mAck, tag);
  endtask

  task automatic doOp(input bit s, input logic [1:0] src, input logic [2:0] dst,
                      input logic [11:0] pay, input logic [36:0] dl,
                      input bit step, input bit endm, input bit di, input bit ti,
                      input bit sig, input bit ship, input bit abrt, input string tag);
    bit nA, nB, nAo, nBo;
    bit wr;
    @(negedge clk); #1;
    execSet = s; setSrc = src; setDst = dst; payload = pay; dataLatch = dl;
    moveStep = step; moveEnd = endm; moveDi = di; moveTi = ti;
    sigBit = sig; shipFlag = ship; abortTorp = abrt;
    @(posedge clk); #1;
    execSet = 0; moveStep = 0; moveEnd = 0; abortTorp = 0;
    // outer counter
    wr = 0;
    if (abrt) begin mOlc = 0; wr = 1; end
    else if (s && dst == 3'b000) begin
      if (src == 2'b00) begin mOlc = int'(pay[5:0]); wr = 1; end
      else if (src == 2'b01) begin mOlc = int'(dl[5:0]); wr = 1; end
      else if (src == 2'b10) begin mOlc = (mOlc == 0) ? 0 : mOlc - 1; wr = 1; end
    end
    mEvt = wr && (mOlc == 0);
    // inner counter
    if (s && dst == 3'b001) begin
      if (src == 2'b00) begin mIlc = int'(pay[5:0]); mInf = 0; end
      else if (src == 2'b01) begin mIlc = int'(dl[5:0]); mInf = 0; end
      else if (src == 2'b10) mInf = 1;
    end else if (endm) begin mIlc = 1; mInf = 0; end
    else if (step && !mInf && mIlc != 0) mIlc = mIlc - 1;
    // flags
    if (s && dst == 3'b111) begin
      nA = pickOr(pay[5:0], mA, mB, mC);   nB = pickOr(pay[11:6], mA, mB, mC);
      nAo = pickOr(pay[5:0], mAo, mBo, mCo); nBo = pickOr(pay[11:6], mAo, mBo, mCo);
      mA = nA; mB = nB; mAo = nAo; mBo = nBo;
    end
    if (step && (di || ti)) mC = sig;
    if (step) begin
      if (di) mCo = ship;
      else if (ti) mCo = sig;
    end
    if (s && dst == 3'b010) mAck = int'(pay[10:0]);
    pushState(tag);
  endtask

  task automatic probe(input logic [2:0] code, input string tag);
    @(negedge clk); #1;
    predCode = code;
    expectItem(K_PRED, int'(predModel(code, mA, mB, mC, mOlc)), tag);
    expectItem(K_PREDO, int'(predModel(code, mAo, mBo, mCo, mOlc)), tag);
  endtask

  task automatic setOp(input logic [1:0] src, input logic [2:0] dst,
                       input logic [11:0] pay, input logic [36:0] dl, input string tag);
    doOp(1, src, dst, pay, dl, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic moveOp(input bit step, input bit endm, input bit di, input bit ti,
                        input bit sig, input bit ship, input string tag);
    doOp(0, 2'b00, 3'b000, 12'h0, 37'h0, step, endm, di, ti, sig, ship, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;
    pushState("R12 reset state");
    probe(3'b111, "R1 always true at reset");
    probe(3'b110, "R1 olc gate at reset");
    probe(3'b000, "R1 A=0 gated by zero olc");

    setOp(2'b00, 3'b000, 12'd3, 37'h0, "R2 olc from payload");
    probe(3'b110, "R1 olc nonzero");
    probe(3'b000, "R1 A=0");
    probe(3'b001, "R1 A=1 false");

    setOp(2'b00, 3'b111, {6'b000100, 6'b010000}, 37'h0, "R8 flags from complements");
    probe(3'b001, "R8 A set");
    probe(3'b011, "R8 B set");
    probe(3'b000, "R8 A=0 false");
    setOp(2'b00, 3'b111, {6'b100000, 6'b000000}, 37'h0, "R8 all-zero field and self copy");
    probe(3'b001, "R8 A cleared");
    probe(3'b011, "R8 B kept");
    setOp(2'b00, 3'b111, {6'b000011, 6'b110000}, 37'h0, "R8 or with complement");
    probe(3'b001, "R8 A forced one");
    probe(3'b010, "R8 B forced one");

    moveOp(1, 0, 1, 0, 1, 0, "R9 R10 di step");
    probe(3'b101, "R9 C from signal / R10 C from ship");
    moveOp(1, 0, 0, 0, 0, 1, "R9 no input keeps C");
    probe(3'b101, "R9 C unchanged");
    moveOp(1, 0, 0, 1, 0, 1, "R9 R10 ti step");
    probe(3'b100, "R9 R10 C from signal on ti");
    moveOp(1, 0, 1, 1, 0, 1, "R10 di beats ti");
    probe(3'b101, "R10 ship value wins");

    setOp(2'b00, 3'b001, 12'd2, 37'h0, "R5 ilc from payload");
    moveOp(1, 0, 0, 0, 0, 0, "R6 step one");
    moveOp(1, 0, 0, 0, 0, 0, "R6 step to zero");
    moveOp(1, 0, 0, 0, 0, 0, "R6 step at zero");
    moveOp(0, 1, 0, 0, 0, 0, "R7 end restores one");
    setOp(2'b10, 3'b001, 12'h0, 37'h0, "R5 ilc forever");
    moveOp(1, 0, 0, 0, 0, 0, "R6 forever holds");
    moveOp(1, 0, 0, 0, 0, 0, "R6 forever holds again");
    moveOp(0, 1, 0, 0, 0, 0, "R7 end leaves forever");
    setOp(2'b01, 3'b001, 12'h0, 37'h1f_0000_0000, "R5 ilc from data latch");
    moveOp(0, 1, 0, 0, 0, 0, "R7 end from zero");

    setOp(2'b10, 3'b000, 12'h0, 37'h0, "R2 R4 decrement");
    setOp(2'b10, 3'b000, 12'h0, 37'h0, "R2 R4 decrement");
    setOp(2'b10, 3'b000, 12'h0, 37'h0, "R2 R4 decrement to zero");
    moveOp(0, 0, 0, 0, 0, 0, "R4 pulse is single");
    setOp(2'b10, 3'b000, 12'h0, 37'h0, "R2 decrement at zero");
    setOp(2'b01, 3'b000, 12'h0, 37'h1f_ffff_ffc5, "R2 olc from data latch");
    probe(3'b110, "R2 olc nonzero from data");
    doOp(1, 2'b00, 3'b000, 12'd9, 37'h0, 0, 0, 0, 0, 0, 0, 1, "R3 abort beats set");
    probe(3'b110, "R3 olc zero after abort");
    setOp(2'b00, 3'b000, 12'd4, 37'h0, "R2 reload");
    doOp(0, 2'b00, 3'b000, 12'h0, 37'h0, 0, 0, 0, 0, 0, 0, 1, "R3 R4 abort alone");

    setOp(2'b00, 3'b010, 12'h5a3, 37'h0, "R11 ack path load");
    setOp(2'b00, 3'b010, 12'hfff, 37'h0, "R11 ack path width");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule